// File: doc/BRIEF.md
# Dual-Channel Stretched-Pulse Coincidence Detector

This block decides whether two event inputs fired close enough together in time to be treated as one coincident occurrence. Each input has its own pulse stretcher. A rising edge on an input loads that channel's down-counter with a programmed length. The channel's stretched level then stays high while the counter is nonzero. The two stretched levels are ANDed. Every rising edge of that AND produces a one-cycle coincidence pulse and advances a saturating coincidence counter.

The window is set only by the programmed lengths, in cycles of the block clock. It does not depend on how long the incoming pulses stay high. A long, slow detector pulse therefore cannot widen the window and make events that are far apart look coincident. The inputs are assumed to be already synchronous to the block clock. Each channel length is an ordinary input that the surrounding logic holds steady while events are being classified.

Top module: `coinc_detector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `coincPulse` is 0 and `coincCount` is 0.
- R2: An input counts as having an edge at a clock edge where it is sampled 1 and was sampled 0 at the previous clock edge. The reset state of that previous sample is 0. With a nonzero length L, an edge sampled at clock edge k holds the channel's stretched level high from edge k until edge k+L, which is exactly L cycles.
- R3: Let the two edges be at clock edges ta and tb, with lengths LA and LB. A coincidence is reported when ta < tb+LB and tb < ta+LA. This holds for either order of arrival, including simultaneous edges.
- R4: An edge that arrives while its channel is still stretching reloads the counter with the current length. The stretch then runs L cycles from the new edge.
- R5: An input held high produces only one edge. Staying high never retriggers or extends the stretch.
- R6: `coincPulse` is high for exactly one cycle per rising edge of the AND of the two stretched levels. That cycle is the one following the clock edge after the AND rises. A continuing overlap gives no further pulse.
- R7: `coincCount` increments by one in the same cycle as each `coincPulse`. It is otherwise unchanged, and it holds at all ones instead of wrapping.
- R8: A length of 0 disables its channel. Edges on that channel are ignored, and a running stretch is cleared at the next clock edge.
- R9: The narrowest window is one clock period. With both lengths set to 1, only edges sampled at the same clock edge coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| eventA | input | 1 | Event input of channel A |
| eventB | input | 1 | Event input of channel B |
| stretchLenA | input | LenW | Stretch length of channel A in cycles (0 disables the channel) |
| stretchLenB | input | LenW | Stretch length of channel B in cycles (0 disables the channel) |
| coincPulse | output | 1 | One-cycle pulse per detected coincidence |
| coincCount | output | CountW | Saturating count of coincidences |

## Verification
Directed pairs of edges are placed just inside and just outside the window, in both arrival orders. This separates an off-by-one error in the window from an error in which side is tested. Single-cycle windows with simultaneous edges isolate the minimum-width case.

Further directed cases cover re-triggering inside a stretch, a level held high, and a channel disabled with length 0. Each of these tells a reload, a level-sensitive trigger, or a disable that fails to clear from the correct edge-only behaviour. Long overlaps separate one pulse per overlap from one pulse per cycle. A burst of coincidences, run with a narrow counter, reaches saturation.

A random phase then mixes event densities and lengths, including zero. An interval-based model in the bench predicts every output cycle.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int NumCh = 2;

  typedef struct packed {
    logic [NumCh-1:0] load;
    logic [NumCh-1:0] clear;
    logic             coincRise;
  } coincStrobes_t;
endpackage

// File: rtl/coinc_ctrl.sv
module coinc_ctrl
  import coinc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NumCh-1:0] evIn,
  input  logic [NumCh-1:0] lenZero,
  input  logic [NumCh-1:0] stretched,
  output coincStrobes_t    strobes
);
  logic [NumCh-1:0] evPrev;
  logic             andPrev;
  logic [NumCh-1:0] evEdge;
  logic             andNow;

  assign evEdge = evIn & ~evPrev;
  assign andNow = &stretched;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evPrev  <= '0;
      andPrev <= 1'b0;
    end else begin
      evPrev  <= evIn;
      andPrev <= andNow;
    end
  end

  always_comb begin
    strobes.load      = evEdge & ~lenZero;
    strobes.clear     = lenZero;
    strobes.coincRise = andNow & ~andPrev;
  end
endmodule

// File: rtl/coinc_datapath.sv
module coinc_datapath
  import coinc_pkg::*;
#(
  parameter int LenW   = 8,
  parameter int CountW = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  coincStrobes_t              strobes,
  input  logic [NumCh-1:0][LenW-1:0] stretchLen,
  output logic [NumCh-1:0]           stretched,
  output logic                       coincPulse,
  output logic [CountW-1:0]          coincCount
);
  localparam logic [CountW-1:0] CountMax = '1;

  for (genvar ch = 0; ch < NumCh; ch++) begin : gStretch
    logic [LenW-1:0] remain;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        remain <= '0;
      end else if (strobes.clear[ch]) begin
        remain <= '0;
      end else if (strobes.load[ch]) begin
        remain <= stretchLen[ch];
      end else if (remain != '0) begin
        remain <= remain - LenW'(1);
      end
    end

    assign stretched[ch] = (remain != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coincPulse <= 1'b0;
      coincCount <= '0;
    end else begin
      coincPulse <= strobes.coincRise;
      if (strobes.coincRise && coincCount != CountMax)
        coincCount <= coincCount + CountW'(1);
    end
  end
endmodule

// File: rtl/coinc_detector.sv
module coinc_detector
  import coinc_pkg::*;
#(
  parameter int LenW   = 8,
  parameter int CountW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eventA,
  input  logic              eventB,
  input  logic [LenW-1:0]   stretchLenA,
  input  logic [LenW-1:0]   stretchLenB,
  output logic              coincPulse,
  output logic [CountW-1:0] coincCount
);
  coincStrobes_t             strobes;
  logic [NumCh-1:0]          stretched;
  logic [NumCh-1:0][LenW-1:0] lens;
  logic [NumCh-1:0]          lenZero;

  assign lens    = {stretchLenB, stretchLenA};
  assign lenZero = {stretchLenB == '0, stretchLenA == '0};

  coinc_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .evIn      ({eventB, eventA}),
    .lenZero   (lenZero),
    .stretched (stretched),
    .strobes   (strobes)
  );

  coinc_datapath #(.LenW(LenW), .CountW(CountW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .stretchLen (lens),
    .stretched  (stretched),
    .coincPulse (coincPulse),
    .coincCount (coincCount)
  );
endmodule

// File: rtl/coinc_checker.sv
module coinc_checker #(
  parameter int LenW   = 8,
  parameter int CountW = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              eventA,
  input logic [LenW-1:0]   stretchLenA,
  input logic [LenW-1:0]   stretchLenB,
  input logic [1:0]        stretched,
  input logic              coincPulse,
  input logic [CountW-1:0] coincCount
);
  // R6: a pulse never lasts two cycles
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    coincPulse |=> !coincPulse);

  // R7: the count moves only by one, and only together with a pulse
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (coincCount != $past(coincCount)) |->
      (coincPulse && coincCount == $past(coincCount) + CountW'(1)));

  // R7: once full, the count stays full
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (&coincCount) |=> (&coincCount));

  // R8: a zero length forces the channel off at the next edge
  a_r8_disable_a: assert property (@(posedge clk) disable iff (!rstN)
    (stretchLenA == '0) |=> !stretched[0]);
  a_r8_disable_b: assert property (@(posedge clk) disable iff (!rstN)
    (stretchLenB == '0) |=> !stretched[1]);

  // R2: a fresh edge with a nonzero length starts the stretch
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && eventA && !$past(eventA) && stretchLenA != '0) |=> stretched[0]);
endmodule

bind coinc_detector coinc_checker #(.LenW(LenW), .CountW(CountW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .eventA      (eventA),
  .stretchLenA (stretchLenA),
  .stretchLenB (stretchLenB),
  .stretched   (stretched),
  .coincPulse  (coincPulse),
  .coincCount  (coincCount)
);

// File: tb/tb_coinc_detector.sv
`timescale 1ns/1ps
module tb_coinc_detector;
  localparam int LenW   = 8;
  localparam int CountW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eventA = 1'b0, eventB = 1'b0;
  logic [LenW-1:0] lenA = '0, lenB = '0;
  logic coincPulse;
  logic [CountW-1:0] coincCount;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;
  string curReq = "R1";

  // model state (interval formulation)
  int  cyc = 0;
  bit  prevA = 0, prevB = 0;
  bit  validA = 0, validB = 0;
  int  lastA = 0, lastB = 0, llA = 0, llB = 0;
  bit  andD1 = 0, andD2 = 0;
  bit  expPulse = 0;
  int  expCount = 0;

  always #2.5 clk = ~clk;

  coinc_detector #(.LenW(LenW), .CountW(CountW)) dut (
    .clk(clk), .rstN(rstN), .eventA(eventA), .eventB(eventB),
    .stretchLenA(lenA), .stretchLenB(lenB),
    .coincPulse(coincPulse), .coincCount(coincCount)
  );

  function automatic bit inWindow(bit v, int last, int ll, int k);
    return v && (k - last < ll);
  endfunction

  task automatic check(bit actP, int actC);
    vectors++;
    if (actP !== expPulse || actC != expCount) begin
      errors++;
      $display("FAIL %s cycle %0d: pulse=%0b count=%0d expected pulse=%0b count=%0d",
               curReq, cyc, actP, actC, expPulse, expCount);
    end
  endtask

  // Apply one cycle of inputs, advance the model by one clock edge, compare.
  task automatic step(bit a, bit b);
    bit hA, hB;
    eventA = a; eventB = b;
    @(posedge clk);
    cyc++;
    if (lenA == 0) validA = 0;
    else if (a && !prevA) begin validA = 1; lastA = cyc; llA = int'(lenA); end
    if (lenB == 0) validB = 0;
    else if (b && !prevB) begin validB = 1; lastB = cyc; llB = int'(lenB); end
    prevA = a; prevB = b;
    hA = inWindow(validA, lastA, llA, cyc);
    hB = inWindow(validB, lastB, llB, cyc);
    expPulse = andD1 && !andD2;
    if (expPulse && expCount < (1 << CountW) - 1) expCount++;
    andD2 = andD1;
    andD1 = hA && hB;
    @(negedge clk);
    check(coincPulse, int'(coincCount));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  // Edge on A, then an edge on B d cycles later (negative d: B first).
  task automatic pair(int d);
    if (d == 0) step(1, 1);
    else if (d > 0) begin
      step(1, 0);
      for (int i = 1; i < d; i++) step(0, 0);
      step(0, 1);
    end else begin
      step(0, 1);
      for (int i = 1; i < -d; i++) step(0, 0);
      step(1, 0);
    end
    idle(12);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      vectors++;
      $display("FAIL watchdog expired (actual running, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    int startCount;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(coincPulse, int'(coincCount));
    rstN = 1'b1;
    idle(1);

    curReq = "R2"; lenA = 4; lenB = 4;
    pair(3); pair(4);
    curReq = "R3";
    pair(-3); pair(-4); pair(0);
    lenA = 2; lenB = 6; pair(1); pair(2); pair(-5); pair(-6);
    curReq = "R9"; lenA = 1; lenB = 1;
    pair(0); pair(1); pair(-1);

    curReq = "R4"; lenA = 4; lenB = 4;
    step(1, 0); step(0, 0); step(0, 0); step(1, 0);
    step(0, 0); step(0, 0); step(0, 1); idle(12);
    if (expCount != int'(coincCount)) ; // compared each cycle

    curReq = "R5"; lenA = 3; lenB = 3;
    for (int i = 0; i < 5; i++) step(1, 0);
    step(1, 1); step(0, 0); idle(10);

    curReq = "R6"; lenA = 20; lenB = 20;
    startCount = expCount;
    step(1, 1); idle(25);
    vectors++;
    if (expCount != startCount + 1) begin
      errors++;
      $display("FAIL R6 long overlap: count delta=%0d expected 1", expCount - startCount);
    end

    curReq = "R8"; lenA = 5; lenB = 0;
    pair(0); pair(2);
    lenB = 10; step(0, 1); step(0, 0); lenB = 0; step(0, 0);
    lenB = 5; step(1, 0); idle(12);

    curReq = "R7"; lenA = 1; lenB = 1;
    for (int i = 0; i < 40; i++) begin step(1, 1); step(0, 0); step(0, 0); end
    idle(4);

    curReq = "R2/R3/R4/R6/R8 random";
    for (int seg = 0; seg < 60; seg++) begin
      lenA = ($urandom % 8 == 0) ? '0 : LenW'(1 + $urandom % 6);
      lenB = ($urandom % 8 == 0) ? '0 : LenW'(1 + $urandom % 6);
      for (int i = 0; i < 50; i++)
        step(($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    idle(10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule